// File: doc/BRIEF.md
# Per-Stage Test Phase Sequencer

This block steps a pipelined converter built from cascaded 1.5-bit stages through its per-stage linearity test phases. It drives a vector with one bit per stage. When a bit is high, that stage must have the low bit of its coarse decision held at zero before error correction. Holding that bit at zero makes the stage's transition edges show up as clear jumps in the output codes under a slow ramp. When the vector is all zero, nothing is forced and the converter runs normally.

A single external test pin advances the sequence. The pin is brought into the clock domain by a synchronizer chain and filtered by a debounce counter. Only its rising edge is used, so one press moves the sequence by exactly one step. The order is: normal, stage 1, stage 2, and so on up to the last stage, then back to normal. Reset always returns the block to normal. If the state register ever holds more than one set bit, the block returns to normal on the next clock.

Top module: `stage_test_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `phase_force` all zero and `normal_mode` high.
- R2: From the normal state, one accepted press sets `phase_force` to 1: bit 0 set, which targets stage 1.
- R3: When bit i is set and i is below the last stage, one accepted press moves the single set bit to i+1 and changes no other bit.
- R4: When the last bit (bit NUM_STAGES-1) is set, one accepted press returns `phase_force` to all zero.
- R5: `normal_mode` is high in exactly those cycles in which `phase_force` is all zero.
- R6: `phase_force` never has more than one bit set. A state holding two or more set bits is cleared to all zero on the next clock.
- R7: A high pulse on `test_pin` that lasts fewer than DEBOUNCE_CYCLES clock cycles leaves `phase_force` unchanged.
- R8: A burst of chatter on `test_pin` that settles high counts as exactly one press. Releasing the pin (a high-to-low change) never advances the sequence.
- R9: A reset applied partway through the sequence returns the block to the normal state, and the next press then targets stage 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_pin | input | 1 | Raw asynchronous test trigger from the external switch |
| phase_force | output | NUM_STAGES | One bit per stage. A high bit forces that stage's coarse low bit to zero |
| normal_mode | output | 1 | High when no stage is being forced |

## Verification
The bench builds the block with the default eight stages and a debounce length of 4 cycles. With the short debounce, a full walk through all eight phases and the wrap back to normal fits in a few hundred cycles. It also makes it cheap to drive pulses just shorter than the debounce length and bursts of one-cycle chatter. A reset partway through, followed by a fresh press, shows that the sequence restarts at stage 1.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    RING_HOLD  = 2'd0,
    RING_STEP  = 2'd1,
    RING_CLEAR = 2'd2
  } ring_cmd_e;
endpackage

// File: rtl/tps_sync.sv
module tps_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] chain_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ff
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= din;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/tps_debounce.sv
module tps_debounce #(
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise_pulse
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;
  logic             stable_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (level_in == stable_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q    <= '0;
      stable_q <= level_in;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stable_d_q <= 1'b0;
    else     stable_d_q <= stable_q;
  end

  assign rise_pulse = stable_q & ~stable_d_q;
endmodule

// File: rtl/tps_ring.sv
module tps_ring
  import tps_pkg::*;
#(
  parameter int NUM_STAGES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  output logic [NUM_STAGES-1:0] phase_q,
  output logic                  normal_q
);
  localparam int POP_W = $clog2(NUM_STAGES + 1);

  logic [POP_W-1:0]      pop;
  logic [NUM_STAGES-1:0] phase_nxt;
  ring_cmd_e             cmd;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NUM_STAGES; i++) pop = pop + POP_W'(phase_q[i]);
  end

  always_comb begin
    if (pop > POP_W'(1)) cmd = RING_CLEAR;
    else if (step)       cmd = RING_STEP;
    else                 cmd = RING_HOLD;
  end

  always_comb begin
    if (phase_q == '0) phase_nxt = NUM_STAGES'(1);
    else               phase_nxt = phase_q << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      normal_q <= 1'b1;
    end else begin
      case (cmd)
        RING_CLEAR: begin
          phase_q  <= '0;
          normal_q <= 1'b1;
        end
        RING_STEP: begin
          phase_q  <= phase_nxt;
          normal_q <= (phase_nxt == '0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stage_test_sequencer.sv
module stage_test_sequencer #(
  parameter int NUM_STAGES      = 8,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int SYNC_DEPTH      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  test_pin,
  output logic [NUM_STAGES-1:0] phase_force,
  output logic                  normal_mode
);
  logic pin_sync;
  logic adv_pulse;

  tps_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (test_pin),
    .dout (pin_sync)
  );

  tps_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk        (clk),
    .rst        (rst),
    .level_in   (pin_sync),
    .rise_pulse (adv_pulse)
  );

  tps_ring #(.NUM_STAGES(NUM_STAGES)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .step     (adv_pulse),
    .phase_q  (phase_force),
    .normal_q (normal_mode)
  );
endmodule

// File: rtl/stage_test_sequencer_chk.sv
module stage_test_sequencer_chk #(
  parameter int NUM_STAGES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  adv_pulse,
  input logic [NUM_STAGES-1:0] phase_force,
  input logic                  normal_mode
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (phase_force == '0) && normal_mode);

  assert_first_stage_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_force == '0 && adv_pulse) |=> phase_force == NUM_STAGES'(1));

  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_force != '0 && !phase_force[NUM_STAGES-1] && adv_pulse
     && $onehot0(phase_force))
    |=> phase_force == ($past(phase_force) << 1));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_force[NUM_STAGES-1] && adv_pulse) |=> phase_force == '0);

  assert_normal_flag_R5: assert property (@(posedge clk) disable iff (rst)
    normal_mode == (phase_force == '0));

  assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_force));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv_pulse |=> $stable(phase_force));
endmodule

bind stage_test_sequencer stage_test_sequencer_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .adv_pulse   (adv_pulse),
  .phase_force (phase_force),
  .normal_mode (normal_mode)
);

// File: tb/tb_stage_test_sequencer.sv
module tb_stage_test_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int DEB = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         test_pin = 1'b0;
  logic [N-1:0] phase_force;
  logic         normal_mode;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  logic [N-1:0] expq[$];
  string        tagq[$];
  logic [N-1:0] last_seen = '0;
  bit           mon_on = 1'b0;
  bit           done = 1'b0;

  stage_test_sequencer #(.NUM_STAGES(N), .DEBOUNCE_CYCLES(DEB)) dut (
    .clk(clk), .rst(rst), .test_pin(test_pin),
    .phase_force(phase_force), .normal_mode(normal_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Driver: one clean press, expected next state pushed to the scoreboard
  task automatic press(input string tag);
    if (model == '0) model = N'(1);
    else             model = model << 1;
    expq.push_back(model);
    tagq.push_back(tag);
    test_pin = 1'b1;
    cycles(DEB + 10);
    test_pin = 1'b0;
    cycles(DEB + 10);
  endtask

  // Monitor: samples at the falling edge, pops on each output change
  always @(negedge clk) begin
    if (mon_on && !done) begin
      check(normal_mode == (phase_force == '0), "R5 normal flag",
            {{(N-1){1'b0}}, normal_mode}, {{(N-1){1'b0}}, phase_force == '0});
      check($countones(phase_force) <= 1, "R6 at most one phase", phase_force, last_seen);
      if (phase_force !== last_seen) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7/R8 unexpected advance", phase_force, last_seen);
        end else begin
          logic [N-1:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(phase_force === e, t, phase_force, e);
        end
        last_seen = phase_force;
      end
    end
  end

  initial begin
    cycles(3);
    check(phase_force == '0 && normal_mode, "R1 reset state", phase_force, '0);
    rst = 1'b0;
    mon_on = 1'b1;
    cycles(3);

    press("R2 first press selects stage 1");
    for (int s = 1; s < N; s++) press("R3 press moves to next stage");
    press("R4 last stage wraps to normal");

    // R7: short pulse below the debounce length
    press("R2 press after wrap");
    test_pin = 1'b1;
    cycles(DEB - 2);
    test_pin = 1'b0;
    cycles(DEB + 12);
    check(phase_force == model, "R7 short pulse ignored", phase_force, model);

    // R8: chatter settling high counts once; the release adds nothing
    if (model == '0) model = N'(1); else model = model << 1;
    expq.push_back(model);
    tagq.push_back("R8 chatter counts once");
    for (int i = 0; i < 12; i++) begin
      test_pin = ~test_pin;
      cycles(1);
    end
    test_pin = 1'b1;
    cycles(DEB + 10);
    test_pin = 1'b0;
    cycles(DEB + 12);
    check(phase_force == model, "R8 release does not advance", phase_force, model);

    press("R3 press mid sequence");

    // R9: reset partway through
    expq.push_back('0);
    tagq.push_back("R9 reset returns to normal");
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    model = '0;
    cycles(3);
    check(phase_force == '0 && normal_mode, "R1 R9 state after reset", phase_force, '0);
    press("R9 press after reset targets stage 1");

    cycles(5);
    check(expq.size() == 0, "R2 scoreboard drained",
          N'(expq.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule